// File: doc/BRIEF.md
# USB transceiver reset and wakeup control

This block is a single byte-wide control register for a full-speed USB subsystem. It does two things. Software can start a hard reset of the USB core by writing a 1 to the top bit. The block then drives a core reset pulse for a fixed number of USB clock cycles and drops the request by itself. The request crosses from the register clock into the USB clock domain through a toggle synchroniser, so one write gives one pulse.

The register also holds an enable for asynchronous resume detection. While that enable is set, the transceiver is suspended and the port is in device mode, the block watches the raw D+ and D- levels. A K-state, with D- high and D+ low, sets a latched wakeup request. No clock has to run for this. Once clocks are back, the system clears the latch through a clear input. That input is synchronised with two flops on the register clock.

Top module: `usb_xcvr_ctl`

## Requirements
- R1: After reset, read data is 0x00, core_rst is low and wake_req is low.
- R2: A write with data bit 7 = 1 produces exactly one core_rst pulse lasting RST_CYCLES USB clock cycles (default 2, never below 2). A write with bit 7 = 0 produces no pulse.
- R3: Read data bit 7 is always 0, including while a reset pulse is in progress.
- R4: Bit 6 stores the value last written and reads back at bit 6.
- R5: Bit 5 is the asynchronous resume enable. It stores the value last written and reads back at bit 5.
- R6: Read data bits 4 to 0 are always 0, whatever was written to them.
- R7: With enable = 1, device_mode = 1 and suspended = 1, a K-state (dm = 1, dp = 0) raises wake_req while the USB clock is stopped. wake_req stays high after the K-state ends.
- R8: wake_req stays low in each of these cases: the enable is 0; suspended is 0; the line is in J-state (dp = 1, dm = 0) or SE0 (both 0).
- R9: With device_mode = 0 (host mode), wake_req stays low even when a K-state is present and enabled.
- R10: Holding wake_clr high without a K-state brings wake_req low within three register clock cycles. If a K-state is present at the same time, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register bus clock |
| usb_clk | input | 1 | USB core clock, may be stopped |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| core_rst | output | 1 | Hard reset pulse to the USB core (USB clock domain) |
| device_mode | input | 1 | 1 = device mode, 0 = host mode |
| suspended | input | 1 | Transceiver is in suspend |
| dp | input | 1 | Unfiltered D+ level |
| dm | input | 1 | Unfiltered D- level |
| wake_clr | input | 1 | Clears the latched wakeup request |
| wake_req | output | 1 | Latched asynchronous wakeup request |

## Verification
The bench counts every core_rst rising edge and every high USB cycle. Two kinds of design would fail it: one that drops the toggle crossing and pulses twice or never, and one that cuts the pulse short of RST_CYCLES. Random writes check that bit 7 reads 0 and that bits 4 to 0 stay zero. A design that stored the reset request as a plain bit would instead read back a 1 during the pulse. The wakeup checks run with the USB clock stopped and step through random combinations of enable, mode, suspend and line state, J and SE0 included. A detector gated by a clock, by the wrong line polarity or without the host-mode qualifier would show up there, and so would a latch that forgets the request when the K-state ends or ignores the clear.

// File: rtl/usb_xcvr_ctl_pkg.sv
package usb_xcvr_ctl_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_RESET  = 7;
    localparam int BIT_KEEP   = 6;
    localparam int BIT_RESEN  = 5;

    typedef struct packed {
        logic keep6;      // reserved bit, stored as written
        logic resume_en;  // asynchronous resume enable
    } ctl_fields_t;

    typedef enum logic [1:0] {
        LINE_SE0 = 2'b00,
        LINE_J   = 2'b01,
        LINE_K   = 2'b10,
        LINE_SE1 = 2'b11
    } line_state_t;

    function automatic line_state_t decode_line(input logic dp, input logic dm);
        return line_state_t'({dm, dp});
    endfunction

    function automatic logic [BYTE_W-1:0] pack_read(input ctl_fields_t f);
        logic [BYTE_W-1:0] r;
        r            = '0;
        r[BIT_KEEP]  = f.keep6;
        r[BIT_RESEN] = f.resume_en;
        return r;
    endfunction

endpackage

// File: rtl/usb_sync_chain.sv
module usb_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= 1'b0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= 1'b0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/usb_xcvr_regs.sv
module usb_xcvr_regs
    import usb_xcvr_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output ctl_fields_t       fields,
    output logic              req_tgl
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fields  <= '0;
            req_tgl <= 1'b0;
        end else if (wr_en) begin
            fields.keep6     <= wdata[BIT_KEEP];
            fields.resume_en <= wdata[BIT_RESEN];
            if (wdata[BIT_RESET]) req_tgl <= ~req_tgl;
        end
    end

    assign rdata = pack_read(fields);

    // R5
    resen_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rdata[BIT_RESEN] == $past(wdata[BIT_RESEN]));

    // R2
    req_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[BIT_RESET]) |=> req_tgl != $past(req_tgl));
endmodule

// File: rtl/usb_core_rst_gen.sv
module usb_core_rst_gen #(
    parameter int RST_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic usb_clk,
    input  logic rst,
    input  logic req_tgl,
    output logic core_rst
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic             tgl_s;
    logic             tgl_prev;
    logic             tgl_edge;
    logic [CNT_W-1:0] cnt;

    usb_sync_chain #(.STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk (usb_clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (tgl_s)
    );

    assign tgl_edge = tgl_s ^ tgl_prev;

    always_ff @(posedge usb_clk) begin
        if (rst) begin
            tgl_prev <= 1'b0;
            cnt      <= '0;
        end else begin
            tgl_prev <= tgl_s;
            if (tgl_edge)      cnt <= CNT_W'(RST_CYCLES);
            else if (cnt != 0) cnt <= cnt - 1'b1;
        end
    end

    assign core_rst = (cnt != 0);

    // R2
    pulse_start_chk: assert property (@(posedge usb_clk) disable iff (rst)
        tgl_edge |=> core_rst);

    // R2
    pulse_min_len_chk: assert property (@(posedge usb_clk) disable iff (rst)
        $rose(core_rst) |=> core_rst);
endmodule

// File: rtl/usb_resume_wake.sv
module usb_resume_wake
    import usb_xcvr_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic device_mode,
    input  logic suspended,
    input  logic dp,
    input  logic dm,
    input  logic clr_sync,
    output logic wake_req
);
    logic kdet;
    logic wake_q;

    assign kdet = enable & device_mode & suspended & (decode_line(dp, dm) == LINE_K);

    // set needs no clock; clear is taken on the register clock
    always_ff @(posedge clk or posedge kdet) begin
        if (kdet)                wake_q <= 1'b1;
        else if (rst || clr_sync) wake_q <= 1'b0;
    end

    assign wake_req = wake_q & device_mode;

    // R10
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_sync && !kdet) |=> (!wake_q || kdet));

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_q && !clr_sync) |=> wake_q);
endmodule

// File: rtl/usb_xcvr_ctl.sv
module usb_xcvr_ctl
    import usb_xcvr_ctl_pkg::*;
#(
    parameter int RST_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              reg_clk,
    input  logic              usb_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              core_rst,
    input  logic              device_mode,
    input  logic              suspended,
    input  logic              dp,
    input  logic              dm,
    input  logic              wake_clr,
    output logic              wake_req
);
    ctl_fields_t fields;
    logic        req_tgl;
    logic        clr_s;

    usb_xcvr_regs u_regs (
        .clk     (reg_clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .fields  (fields),
        .req_tgl (req_tgl)
    );

    usb_core_rst_gen #(
        .RST_CYCLES  (RST_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rst_gen (
        .usb_clk  (usb_clk),
        .rst      (rst),
        .req_tgl  (req_tgl),
        .core_rst (core_rst)
    );

    usb_sync_chain #(.STAGES(2)) u_clr_sync (
        .clk (reg_clk),
        .rst (rst),
        .d   (wake_clr),
        .q   (clr_s)
    );

    usb_resume_wake u_wake (
        .clk         (reg_clk),
        .rst         (rst),
        .enable      (fields.resume_en),
        .device_mode (device_mode),
        .suspended   (suspended),
        .dp          (dp),
        .dm          (dm),
        .clr_sync    (clr_s),
        .wake_req    (wake_req)
    );

    // R3
    rd_reset_bit_chk: assert property (@(posedge reg_clk) disable iff (rst)
        core_rst |-> !rdata[BIT_RESET]);

    // R9
    host_no_wake_chk: assert property (@(posedge reg_clk) disable iff (rst)
        !device_mode |-> !wake_req);
endmodule

// File: tb/usb_xcvr_ctl_tb_top.sv
module usb_xcvr_ctl_tb_top;
    localparam int RSTC = 2;

    logic       reg_clk = 1'b0;
    logic       usb_clk = 1'b0;
    logic       usb_run = 1'b1;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       core_rst;
    logic       device_mode = 1'b0;
    logic       suspended = 1'b0;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic       wake_clr = 1'b0;
    logic       wake_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int hi_cyc = 0;
    bit m_keep = 0;
    bit m_en   = 0;

    usb_xcvr_ctl #(.RST_CYCLES(RSTC)) dut_i (
        .reg_clk(reg_clk), .usb_clk(usb_clk), .rst(rst),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .core_rst(core_rst),
        .device_mode(device_mode), .suspended(suspended),
        .dp(dp), .dm(dm), .wake_clr(wake_clr), .wake_req(wake_req)
    );

    always #5 reg_clk = ~reg_clk;
    always #7 if (usb_run) usb_clk = ~usb_clk;

    always @(posedge core_rst) pulses++;
    always @(posedge usb_clk) if (core_rst) hi_cyc++;

    function automatic logic [7:0] exp_read(bit k, bit e);
        return {1'b0, k, e, 5'b00000};
    endfunction

    function automatic bit exp_wake(bit en, bit dev, bit sus, bit p, bit m);
        return en & dev & sus & m & ~p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge reg_clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge reg_clk);
        wr_en = 1'b0;
        if (d[7] == 1'b0 || 1) begin
            m_keep = d[6];
            m_en   = d[5];
        end
    endtask

    task automatic reset_write_check(logic [7:0] d);
        int p0, h0;
        p0 = pulses;
        h0 = hi_cyc;
        wr(d);
        repeat (3) @(negedge reg_clk);
        check("R3", rdata[7], 1'b0);
        repeat (20) @(negedge reg_clk);
        check("R2 pulses", pulses - p0, d[7] ? 1 : 0);
        check("R2 length", hi_cyc - h0, d[7] ? RSTC : 0);
        check("R6", rdata[4:0], 5'b0);
        check("R4/R5 readback", rdata, exp_read(m_keep, m_en));
    endtask

    task automatic wake_case(bit en, bit dev, bit sus, bit p, bit m);
        bit e;
        e = exp_wake(en, dev, sus, p, m);
        wr({1'b0, 1'b1, en, 5'b0});
        device_mode = dev;
        suspended   = sus;
        @(negedge reg_clk);
        usb_run = 1'b0;
        #2 dp = p; dm = m;
        #2;
        check(e ? "R7 set" : "R8/R9 no wake", wake_req, e);
        #1 dp = 1'b1; dm = 1'b0;
        @(negedge reg_clk);
        check(e ? "R7 hold" : "R8/R9 still low", wake_req, e);
        wake_clr = 1'b1;
        repeat (4) @(negedge reg_clk);
        check("R10 clear", wake_req, 1'b0);
        wake_clr = 1'b0;
        repeat (3) @(negedge reg_clk);
        usb_run = 1'b1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (6) @(negedge reg_clk);
        rst = 1'b0;
        @(negedge reg_clk);
        check("R1 rdata", rdata, 8'h00);
        check("R1 core_rst", core_rst, 1'b0);
        check("R1 wake_req", wake_req, 1'b0);

        // directed reset requests
        reset_write_check(8'h80);
        reset_write_check(8'hFF);
        reset_write_check(8'h7F);
        reset_write_check(8'h40);

        // random register writes
        for (int i = 0; i < 30; i++) begin
            reset_write_check(8'($urandom));
        end

        // directed wakeup corners: K, J, SE0, disabled, host, not suspended
        wake_case(1, 1, 1, 0, 1);   // R7
        wake_case(1, 1, 1, 1, 0);   // R8 J
        wake_case(1, 1, 1, 0, 0);   // R8 SE0
        wake_case(0, 1, 1, 0, 1);   // R8 disabled
        wake_case(1, 1, 0, 0, 1);   // R8 not suspended
        wake_case(1, 0, 1, 0, 1);   // R9 host

        for (int i = 0; i < 40; i++) begin
            wake_case(1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom));
        end

        // R10: set takes priority while K persists
        wr(8'h60);
        device_mode = 1'b1;
        suspended   = 1'b1;
        dp = 1'b0; dm = 1'b1;
        wake_clr = 1'b1;
        repeat (5) @(negedge reg_clk);
        check("R10 set priority", wake_req, 1'b1);
        dp = 1'b1; dm = 1'b0;
        repeat (4) @(negedge reg_clk);
        check("R10 clear after K", wake_req, 1'b0);
        wake_clr = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule